// File: doc/BRIEF.md
# Program Memory Checksum Accumulator

This block folds a stream of memory words into a 16-bit checksum the way a device programmer reports it. After a clear pulse it accepts program-memory words first, then one configuration word, and, when the part is code protected, a fixed number of ID words. Each accepted word goes through a masking stage before it is added. The adder keeps only the low 16 bits of every sum.

With protection off, every program word up to the top user address adds its low 14 bits. The configuration word, masked to 14 bits, closes the run. With protection on, program words still pass through the stream but each one adds zero. The masked configuration word is followed by the ID words, and the low nibble of ID word k is placed at bits 4k+3:4k before it is added. The protection mode is captured at the clear pulse. `sum_valid` rises once the final word of the mode has been taken. From then on the sum stays frozen until the next clear.

The program depth is a parameter. A 1K-word part and a 0.5K-word part can share one word stream, and each instance drops the program words beyond its own top address.

Top module: `prog_cksum_acc`

## Requirements
- R1: Reset or a clear pulse (`clr`=1 on a clock edge) sets `sum` to 0 and `sum_valid` to 0 in the next cycle. A word presented in the same cycle as the clear is dropped.
- R2: In unprotected mode each accepted program word (`wkind`=0) adds `wdata[13:0]` to `sum`, and `wdata[15:14]` are ignored. The new sum appears one clock after the word.
- R3: All additions are modulo 2^16, so a carry out of bit 15 is discarded.
- R4: Only the first PROG_DEPTH program words after a clear are accepted, and later program words leave `sum` unchanged. A blank part (all words 0x3FFF, configuration 0x3FFF) gives 0x3BFF for PROG_DEPTH=1024 and 0x3DFF for PROG_DEPTH=512.
- R5: The first configuration word (`wkind`=1) adds `wdata & 0x3FFF` and ends the program phase. In unprotected mode `sum_valid` is 1 from the next clock.
- R6: In protected mode each program word adds zero, so `sum` does not change.
- R7: In protected mode the configuration word is followed by ID words (`wkind`=2). The k-th ID word (k=0..3) adds `(wdata & 0xF) << 4k`. `sum_valid` rises one clock after the fourth ID word and not earlier.
- R8: While `sum_valid` is 1, words of every kind leave `sum` unchanged.
- R9: A word out of sequence is ignored: an ID word before the configuration word or in unprotected mode, a program word after the configuration word, a second configuration word, and any `wkind`=3.
- R10: The mode is set by `protect` as sampled at the clear pulse (0 after reset). Changing `protect` later in the run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start/clear pulse; samples `protect` |
| protect | input | 1 | Code-protect flag, captured at `clr` |
| wvalid | input | 1 | Word strobe, one word per cycle |
| wkind | input | 2 | Word type: 0 program, 1 configuration, 2 ID, 3 ignored |
| wdata | input | 16 | Word value as read |
| sum | output | 16 | Running checksum |
| sum_valid | output | 1 | Checksum complete |

## Verification
The bench runs blank and patterned streams through a 1K and a 0.5K instance side by side. A design with the wrong mask would miss 0x3BFF and 0x3DFF, a design that keeps carries or counts words past the top would wrap wrongly, and a design with an off-by-one depth would accept one extra word on the smaller instance. In protected mode it sweeps every ID nibble value in every lane. A swapped lane shift or an early `sum_valid` after the third ID word would show up there. It also sends words out of sequence, flips `protect` partway through a run and clears in the middle of a run. These catch a design that samples the mode live or keeps adding after completion.

// File: rtl/pca_pkg.sv
package pca_pkg;
   typedef enum logic [1:0] {
      K_PROG = 2'd0,
      K_CFG  = 2'd1,
      K_ID   = 2'd2,
      K_NONE = 2'd3
   } word_kind_t;

   typedef enum logic [1:0] {
      PH_PROG = 2'd0,
      PH_ID   = 2'd1,
      PH_DONE = 2'd2
   } phase_t;
endpackage

// File: rtl/pca_word_mask.sv
module pca_word_mask
   import pca_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int DATA_W   = 14,
   parameter int SUM_W    = 16,
   parameter int ID_COUNT = 4,
   parameter int ID_NIB   = 4,
   localparam int IDX_W   = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
   input  logic [WORD_W-1:0] word,
   input  word_kind_t        kind,
   input  logic              prot,
   input  logic [IDX_W-1:0]  id_idx,
   output logic [SUM_W-1:0]  addend
);
   logic [SUM_W-1:0] data_ext;
   logic [SUM_W-1:0] lane [ID_COUNT];
   logic [SUM_W-1:0] id_term;

   generate
      if (DATA_W == SUM_W) begin : g_full
         assign data_ext = word[DATA_W-1:0];
      end else begin : g_pad
         assign data_ext = {{(SUM_W-DATA_W){1'b0}}, word[DATA_W-1:0]};
      end
   endgenerate

   for (genvar k = 0; k < ID_COUNT; k++) begin : g_lane
      assign lane[k] = (id_idx == IDX_W'(k))
                     ? (SUM_W'(word[ID_NIB-1:0]) << (k*ID_NIB)) : '0;
   end

   always_comb begin
      id_term = '0;
      for (int k = 0; k < ID_COUNT; k++) id_term = id_term | lane[k];
   end

   always_comb begin
      unique case (kind)
         K_PROG:  addend = prot ? '0 : data_ext;
         K_CFG:   addend = data_ext;
         K_ID:    addend = id_term;
         default: addend = '0;
      endcase
   end
endmodule

// File: rtl/pca_seq.sv
module pca_seq
   import pca_pkg::*;
#(
   parameter int PROG_DEPTH = 1024,
   parameter int ID_COUNT   = 4,
   localparam int CNT_W     = $clog2(PROG_DEPTH + 1),
   localparam int IDX_W     = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             protect,
   input  logic             wvalid,
   input  word_kind_t       kind,
   output logic             take,
   output logic             prot_q,
   output logic [IDX_W-1:0] id_idx,
   output logic             done
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(PROG_DEPTH);
   localparam logic [IDX_W-1:0] LAST_ID = IDX_W'(ID_COUNT - 1);

   phase_t           phase;
   logic [CNT_W-1:0] prog_cnt;
   logic             take_prog, take_cfg, take_id;

   assign take_prog = (phase == PH_PROG) && (kind == K_PROG) && (prog_cnt < DEPTH_C);
   assign take_cfg  = (phase == PH_PROG) && (kind == K_CFG);
   assign take_id   = (phase == PH_ID)   && (kind == K_ID);
   assign take      = wvalid && !clr && (take_prog || take_cfg || take_id);
   assign done      = (phase == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_PROG;
         prog_cnt <= '0;
         id_idx   <= '0;
         prot_q   <= 1'b0;
      end else if (clr) begin
         phase    <= PH_PROG;
         prog_cnt <= '0;
         id_idx   <= '0;
         prot_q   <= protect;
      end else if (take) begin
         if (take_prog) prog_cnt <= prog_cnt + 1'b1;
         if (take_cfg)  phase    <= prot_q ? PH_ID : PH_DONE;
         if (take_id) begin
            if (id_idx == LAST_ID) phase <= PH_DONE;
            else                   id_idx <= id_idx + 1'b1;
         end
      end
   end

   // R4
   prog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_cnt <= DEPTH_C);

   // R5
   cfg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_q && $rose(done)) |-> $past(wvalid && kind == K_CFG));

   // R7
   id_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && $rose(done)) |-> $past(wvalid && kind == K_ID && id_idx == LAST_ID));
endmodule

// File: rtl/pca_accum.sv
module pca_accum #(
   parameter int SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [SUM_W-1:0] addend,
   output logic [SUM_W-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + addend;
   end

   // R3
   wrap_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> acc == SUM_W'($past(acc) + $past(addend)));
endmodule

// File: rtl/prog_cksum_acc.sv
module prog_cksum_acc
   import pca_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int DATA_W     = 14,
   parameter int SUM_W      = 16,
   parameter int PROG_DEPTH = 1024,
   parameter int ID_COUNT   = 4,
   parameter int ID_NIB     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              protect,
   input  logic              wvalid,
   input  logic [1:0]        wkind,
   input  logic [WORD_W-1:0] wdata,
   output logic [SUM_W-1:0]  sum,
   output logic              sum_valid
);
   localparam int IDX_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;

   generate
      if (DATA_W > WORD_W)            begin : g_e1 $error("DATA_W exceeds WORD_W"); end
      if (DATA_W > SUM_W)             begin : g_e2 $error("DATA_W exceeds SUM_W"); end
      if (ID_NIB > WORD_W)            begin : g_e3 $error("ID_NIB exceeds WORD_W"); end
      if (ID_COUNT * ID_NIB > SUM_W)  begin : g_e4 $error("ID lanes exceed SUM_W"); end
      if (PROG_DEPTH < 1)             begin : g_e5 $error("PROG_DEPTH must be positive"); end
   endgenerate

   word_kind_t       kind;
   logic             take, prot_q, done;
   logic [IDX_W-1:0] id_idx;
   logic [SUM_W-1:0] addend;

   assign kind = word_kind_t'(wkind);

   pca_seq #(.PROG_DEPTH(PROG_DEPTH), .ID_COUNT(ID_COUNT)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr), .protect(protect),
      .wvalid(wvalid), .kind(kind), .take(take), .prot_q(prot_q),
      .id_idx(id_idx), .done(done)
   );

   pca_word_mask #(.WORD_W(WORD_W), .DATA_W(DATA_W), .SUM_W(SUM_W),
                   .ID_COUNT(ID_COUNT), .ID_NIB(ID_NIB)) u_mask (
      .word(wdata), .kind(kind), .prot(prot_q), .id_idx(id_idx), .addend(addend)
   );

   pca_accum #(.SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(take), .addend(addend), .acc(sum)
   );

   assign sum_valid = done;

   // R1
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum == '0 && !sum_valid));

   // R8
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_valid && !clr) |=> $stable(sum));

   // R6
   prot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && !clr && prot_q && kind == K_PROG) |=> $stable(sum));
endmodule

// File: tb/tb_prog_cksum_acc.sv
module tb_prog_cksum_acc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        protect = 1'b0;
   logic        wvalid = 1'b0;
   logic [1:0]  wkind = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] sum_f, sum_h;
   logic        val_f, val_h;

   int checks = 0;
   int errors = 0;

   // bench model per instance: 0 = 1K, 1 = 0.5K
   int          m_depth [2] = '{1024, 512};
   int          m_ph    [2];
   int          m_cnt   [2];
   int          m_idx   [2];
   bit          m_pr    [2];
   logic [15:0] m_sum   [2];

   always #2.5 clk = ~clk;

   prog_cksum_acc dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .protect(protect), .wvalid(wvalid),
      .wkind(wkind), .wdata(wdata), .sum(sum_f), .sum_valid(val_f)
   );

   prog_cksum_acc #(.PROG_DEPTH(512)) dut_half (
      .clk(clk), .rst_n(rst_n), .clr(clr), .protect(protect), .wvalid(wvalid),
      .wkind(wkind), .wdata(wdata), .sum(sum_h), .sum_valid(val_h)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic chk_both(input string req);
      chk({req, " sum 1K"},    sum_f, m_sum[0]);
      chk({req, " sum 0.5K"},  sum_h, m_sum[1]);
      chk({req, " valid 1K"},  {15'd0, val_f}, {15'd0, m_ph[0] == 2});
      chk({req, " valid 0.5K"},{15'd0, val_h}, {15'd0, m_ph[1] == 2});
   endtask

   task automatic model_word(input logic [1:0] k, input logic [15:0] d);
      for (int i = 0; i < 2; i++) begin
         if (m_ph[i] == 0 && k == 2'd0 && m_cnt[i] < m_depth[i]) begin
            m_cnt[i]++;
            if (!m_pr[i]) m_sum[i] = m_sum[i] + (d & 16'h3FFF);
         end else if (m_ph[i] == 0 && k == 2'd1) begin
            m_sum[i] = m_sum[i] + (d & 16'h3FFF);
            m_ph[i]  = m_pr[i] ? 1 : 2;
         end else if (m_ph[i] == 1 && k == 2'd2) begin
            m_sum[i] = m_sum[i] + ((d & 16'hF) << (4 * m_idx[i]));
            if (m_idx[i] == 3) m_ph[i] = 2;
            else               m_idx[i]++;
         end
      end
   endtask

   // inputs change 1 time unit after a rising edge; outputs read at the same point
   task automatic do_clr(input bit p);
      protect = p;
      clr = 1'b1;
      @(posedge clk); #1;
      clr = 1'b0;
      for (int i = 0; i < 2; i++) begin
         m_ph[i] = 0; m_cnt[i] = 0; m_idx[i] = 0; m_pr[i] = p; m_sum[i] = 16'h0;
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [15:0] d);
      wvalid = 1'b1; wkind = k; wdata = d;
      @(posedge clk); #1;
      wvalid = 1'b0;
      model_word(k, d);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [15:0] snap_f, snap_h;
      for (int i = 0; i < 2; i++) begin
         m_ph[i] = 0; m_cnt[i] = 0; m_idx[i] = 0; m_pr[i] = 0; m_sum[i] = 0;
      end
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1;
      // R1 reset state
      chk_both("R1 reset");

      // R4 R3 R5 blank parts: 1024 words of 0x3FFF, upper bits set in config
      do_clr(1'b0);
      for (int a = 0; a < 1024; a++) send(2'd0, 16'h3FFF);
      chk("R4 top word 0.5K frozen", sum_h, 16'((513 - 1) * 16'h3FFF));
      send(2'd1, 16'hFFFF);
      chk("R4 blank 1K", sum_f, 16'h3BFF);
      chk("R4 blank 0.5K", sum_h, 16'h3DFF);
      chk_both("R5 R3 blank done");

      // R8 R9: words after completion ignored
      send(2'd0, 16'h1234);
      send(2'd1, 16'h0F0F);
      send(2'd2, 16'h000F);
      chk_both("R8 after valid");

      // R2 R3 patterned unprotected sweep, upper bits vary
      do_clr(1'b0);
      send(2'd2, 16'h0007);
      chk_both("R9 early ID ignored");
      send(2'd3, 16'h2222);
      chk_both("R9 kind 3 ignored");
      for (int a = 0; a < 700; a++) begin
         send(2'd0, 16'(a * 16'h1357 + 16'hC0A5));
         if (a % 50 == 0) chk_both("R2 pattern");
      end
      // R10 flip protect mid-run has no effect
      protect = 1'b1;
      send(2'd0, 16'h2ABC);
      chk_both("R10 late protect");
      send(2'd1, 16'h4321);
      chk_both("R5 pattern cfg");
      send(2'd0, 16'h0111);
      chk_both("R9 program after cfg");

      // R6 R7 protected: sweep every nibble in every lane
      for (int n = 0; n < 16; n++) begin
         do_clr(1'b1);
         protect = 1'b0; // R10 dropping protect after clear changes nothing
         for (int a = 0; a < 20; a++) send(2'd0, 16'(16'h3FF0 + a));
         chk_both("R6 program zero");
         send(2'd2, 16'h0009);
         chk_both("R9 ID before cfg");
         send(2'd1, 16'(16'hC000 | (n * 16'h0123)));
         send(2'd1, 16'h1111);
         chk_both("R9 second cfg");
         send(2'd0, 16'h0055);
         for (int k = 0; k < 4; k++) begin
            send(2'd2, 16'(16'h3FF0 | ((n + k * 5) & 15)));
            chk_both("R7 ID lane");
         end
         send(2'd2, 16'h000F);
         chk_both("R8 extra ID");
      end

      // R1 clear mid-run, word during clear is dropped
      do_clr(1'b0);
      send(2'd0, 16'h0ABC);
      wvalid = 1'b1; wkind = 2'd0; wdata = 16'h0FFF; clr = 1'b1;
      @(posedge clk); #1;
      wvalid = 1'b0; clr = 1'b0;
      for (int i = 0; i < 2; i++) begin
         m_ph[i] = 0; m_cnt[i] = 0; m_idx[i] = 0; m_pr[i] = 0; m_sum[i] = 0;
      end
      chk_both("R1 mid clear");
      snap_f = sum_f; snap_h = sum_h;
      send(2'd0, 16'h0001);
      chk_both("R2 after clear");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule